// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that moves a parallel-port peripheral out of plain compatibility operation and into a requested bidirectional transfer mode. It also brings the peripheral back again on request. It drives four host control lines and the 8-bit data bus, and it watches five peripheral status lines. The status lines pass through a two-flop synchronizer before the sequencer uses them. Every wait is bounded by a timeout, and each timeout is counted in base ticks that come from a programmable clock prescaler.

A client asks for a mode by pulsing `startReq` with an 8-bit code on `modeCode`. It asks for a return to compatibility by pulsing `stopReq`. Every request ends with a one-cycle `done` pulse and a result code on `result`. The result code stays on `result` until the next request completes. The outputs `curMode` and `modeActive` report the mode in force. Data transfer and bus turnaround belong to other blocks.

Top module: `xmode_negotiator`

## Requirements
- R1: After reset, the pins rest in compatibility idle: outStrobeN, outAutoFdN and outInitN are high, and outSelInN is low. dataOut is 0x00, curMode is 0x00, and modeActive and done are low. outInitN stays high at all times.
- R2: A start request that arrives while outSelInN is already high is refused. `done` pulses with result 4 (I/O error), and the pins and the mode do not change.
- R3: When a negotiation starts, the requested code is placed on dataOut. One setup period later (SETUP_T ticks), outSelInN rises and outAutoFdN falls, while outStrobeN and outInitN stay high. dataOut does not change while outSelInN is high.
- R4: The controller then waits up to SETUP_T+RESP_T ticks for all of these on the synchronized status: paper-error high, select high, fault-n high and ack-n low. If the window expires, the result is 1 (timeout) and the pins return to compatibility idle.
- R5: After the peripheral identifies itself, outStrobeN is pulsed low for one setup period. outStrobeN and outAutoFdN then both go high together.
- R6: The controller then waits up to SETUP_T+RESP_T ticks for ack-n to return high. If the window expires, the result is 2 (protocol error) and the pins return to compatibility idle.
- R7: Code 0x00 (nibble) is always accepted once the handshake completes. Any other code, including 0x30 (run-length-encoded enhanced mode), is accepted only if select is high at that point; otherwise the result is 3 (not supported) and the pins return to idle. On acceptance the result is 0, curMode takes the code, modeActive rises and outSelInN stays high.
- R8: A stop request while modeActive is high works as follows. outSelInN falls with the other controls high, and the controller waits up to SETUP_T+RESP_T ticks for busy and fault-n both high. curMode then becomes 0x00, modeActive falls and outAutoFdN falls. The controller waits up to RESP_T ticks for ack-n high, then raises outAutoFdN and reports result 0.
- R9: If either wait in the stop sequence expires, the result is 1. curMode is still forced to 0x00, modeActive is low, and the pins end in compatibility idle.
- R10: A stop request while modeActive is low completes on the next cycle with result 0, and no pin changes.
- R11: One base tick lasts tickDiv+1 clock cycles. A negotiation that times out during identification therefore completes about (2*SETUP_T+RESP_T)*(tickDiv+1) cycles after the start. The strobe pulse lasts about SETUP_T*(tickDiv+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickDiv | input | DIV_W | Prescaler: one base tick every tickDiv+1 cycles |
| startReq | input | 1 | Pulse: negotiate the mode in modeCode |
| modeCode | input | 8 | Requested mode code |
| stopReq | input | 1 | Pulse: return to compatibility |
| statAckN | input | 1 | Peripheral ack-n status line |
| statBusy | input | 1 | Peripheral busy status line |
| statPaperErr | input | 1 | Peripheral paper-error status line |
| statSel | input | 1 | Peripheral select status line |
| statFaultN | input | 1 | Peripheral fault-n status line |
| outStrobeN | output | 1 | Host strobe-n control line |
| outAutoFdN | output | 1 | Host auto-feed-n control line |
| outInitN | output | 1 | Host init-n control line |
| outSelInN | output | 1 | Host select-in-n control line |
| dataOut | output | 8 | Data bus toward the peripheral |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 protocol error, 3 not supported, 4 I/O error |
| curMode | output | 8 | Mode code in force (0x00 in compatibility) |
| modeActive | output | 1 | High while a negotiated mode is in force |

## Verification
The bench uses the default tick counts (setup 1, response 6). It varies tickDiv between 0 and 3 from one request to the next, so every timeout window closes within a few dozen cycles. Its peripheral model can refuse identification, withhold the acknowledge, deny select, or stall either step of the termination. These knobs let it reach every result code. With them the bench measures the timeout and strobe durations against the prescaler setting.

// File: rtl/xneg_pkg.sv
package xneg_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_PROTO   = 3'd2,
    RES_NOSUP   = 3'd3,
    RES_IOERR   = 3'd4
  } result_e;

  typedef enum logic [1:0] {
    WIN_SETUP = 2'd0,
    WIN_LONG  = 2'd1,
    WIN_RESP  = 2'd2
  } win_e;

  typedef struct packed {
    logic loadWin;
    win_e win;
    logic latchMode;
  } ctlStrobe_t;

  typedef struct packed {
    logic ackN;
    logic busy;
    logic paperErr;
    logic select;
    logic faultN;
  } status_t;
endpackage

// File: rtl/xneg_datapath.sv
module xneg_datapath
  import xneg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SETUP_T     = 1,
  parameter int RESP_T      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic [7:0]       modeCode,
  input  status_t          statRaw,
  output status_t          statSync,
  output logic             winExpired,
  output logic [7:0]       modeLatch
);
  localparam int LONG_T = SETUP_T + RESP_T;
  localparam int TICK_W = $clog2(LONG_T + 1) + 1;

  status_t syncStage [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= statRaw;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign statSync = syncStage[SYNC_STAGES-1];

  logic [DIV_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] winLen;

  always_comb begin
    case (ctl.win)
      WIN_SETUP: winLen = TICK_W'(SETUP_T);
      WIN_LONG:  winLen = TICK_W'(LONG_T);
      default:   winLen = TICK_W'(RESP_T);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.loadWin) begin
      preCnt  <= tickDiv;
      tickCnt <= winLen;
    end else if (tickCnt != '0) begin
      if (preCnt == '0) begin
        preCnt  <= tickDiv;
        tickCnt <= tickCnt - 1'b1;
      end else begin
        preCnt <= preCnt - 1'b1;
      end
    end
  end

  assign winExpired = (tickCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeLatch <= 8'h00;
    else if (ctl.latchMode) modeLatch <= modeCode;
  end
endmodule

// File: rtl/xneg_control.sv
module xneg_control
  import xneg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       stopReq,
  input  status_t    statSync,
  input  logic       winExpired,
  input  logic [7:0] modeLatch,
  output ctlStrobe_t ctl,
  output logic       strobeN,
  output logic       autoFdN,
  output logic       initN,
  output logic       selInN,
  output logic       done,
  output logic [2:0] result,
  output logic [7:0] curMode,
  output logic       modeActive
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAIT_ID, ST_STROBE, ST_WAIT_ACK, ST_TERM_REQ, ST_TERM_ACK
  } state_e;

  state_e state, stateNext;
  logic strobeNxt, autoFdNxt, initNxt, selInNxt, doneNxt, activeNxt;
  logic [2:0] resultNxt;
  logic [7:0] modeNxt;
  logic idPresent;

  assign idPresent = statSync.paperErr && statSync.select && statSync.faultN && !statSync.ackN;

  always_comb begin
    stateNext = state;
    strobeNxt = strobeN;
    autoFdNxt = autoFdN;
    initNxt   = initN;
    selInNxt  = selInN;
    doneNxt   = 1'b0;
    resultNxt = result;
    modeNxt   = curMode;
    activeNxt = modeActive;
    ctl       = '{loadWin: 1'b0, win: WIN_SETUP, latchMode: 1'b0};

    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (selInN) begin
            doneNxt   = 1'b1;
            resultNxt = RES_IOERR;
          end else begin
            ctl       = '{loadWin: 1'b1, win: WIN_SETUP, latchMode: 1'b1};
            stateNext = ST_SETUP;
          end
        end else if (stopReq) begin
          if (modeActive) begin
            strobeNxt = 1'b1;
            autoFdNxt = 1'b1;
            initNxt   = 1'b1;
            selInNxt  = 1'b0;
            ctl       = '{loadWin: 1'b1, win: WIN_LONG, latchMode: 1'b0};
            stateNext = ST_TERM_REQ;
          end else begin
            doneNxt   = 1'b1;
            resultNxt = RES_OK;
          end
        end
      end
      ST_SETUP: begin
        if (winExpired) begin
          selInNxt  = 1'b1;
          autoFdNxt = 1'b0;
          ctl       = '{loadWin: 1'b1, win: WIN_LONG, latchMode: 1'b0};
          stateNext = ST_WAIT_ID;
        end
      end
      ST_WAIT_ID: begin
        if (idPresent) begin
          strobeNxt = 1'b0;
          ctl       = '{loadWin: 1'b1, win: WIN_SETUP, latchMode: 1'b0};
          stateNext = ST_STROBE;
        end else if (winExpired) begin
          {strobeNxt, autoFdNxt, initNxt, selInNxt} = 4'b1110;
          doneNxt   = 1'b1;
          resultNxt = RES_TIMEOUT;
          stateNext = ST_IDLE;
        end
      end
      ST_STROBE: begin
        if (winExpired) begin
          strobeNxt = 1'b1;
          autoFdNxt = 1'b1;
          ctl       = '{loadWin: 1'b1, win: WIN_LONG, latchMode: 1'b0};
          stateNext = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        if (statSync.ackN) begin
          doneNxt   = 1'b1;
          stateNext = ST_IDLE;
          if (modeLatch == 8'h00 || statSync.select) begin
            resultNxt = RES_OK;
            modeNxt   = modeLatch;
            activeNxt = 1'b1;
          end else begin
            {strobeNxt, autoFdNxt, initNxt, selInNxt} = 4'b1110;
            resultNxt = RES_NOSUP;
          end
        end else if (winExpired) begin
          {strobeNxt, autoFdNxt, initNxt, selInNxt} = 4'b1110;
          doneNxt   = 1'b1;
          resultNxt = RES_PROTO;
          stateNext = ST_IDLE;
        end
      end
      ST_TERM_REQ: begin
        if (statSync.busy && statSync.faultN) begin
          modeNxt   = 8'h00;
          activeNxt = 1'b0;
          autoFdNxt = 1'b0;
          ctl       = '{loadWin: 1'b1, win: WIN_RESP, latchMode: 1'b0};
          stateNext = ST_TERM_ACK;
        end else if (winExpired) begin
          modeNxt   = 8'h00;
          activeNxt = 1'b0;
          doneNxt   = 1'b1;
          resultNxt = RES_TIMEOUT;
          stateNext = ST_IDLE;
        end
      end
      ST_TERM_ACK: begin
        if (statSync.ackN || winExpired) begin
          autoFdNxt = 1'b1;
          doneNxt   = 1'b1;
          resultNxt = statSync.ackN ? RES_OK : RES_TIMEOUT;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      strobeN    <= 1'b1;
      autoFdN    <= 1'b1;
      initN      <= 1'b1;
      selInN     <= 1'b0;
      done       <= 1'b0;
      result     <= RES_OK;
      curMode    <= 8'h00;
      modeActive <= 1'b0;
    end else begin
      state      <= stateNext;
      strobeN    <= strobeNxt;
      autoFdN    <= autoFdNxt;
      initN      <= initNxt;
      selInN     <= selInNxt;
      done       <= doneNxt;
      result     <= resultNxt;
      curMode    <= modeNxt;
      modeActive <= activeNxt;
    end
  end
endmodule

// File: rtl/xmode_negotiator.sv
module xmode_negotiator
  import xneg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SETUP_T = 1,
  parameter int RESP_T  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic             startReq,
  input  logic [7:0]       modeCode,
  input  logic             stopReq,
  input  logic             statAckN,
  input  logic             statBusy,
  input  logic             statPaperErr,
  input  logic             statSel,
  input  logic             statFaultN,
  output logic             outStrobeN,
  output logic             outAutoFdN,
  output logic             outInitN,
  output logic             outSelInN,
  output logic [7:0]       dataOut,
  output logic             done,
  output logic [2:0]       result,
  output logic [7:0]       curMode,
  output logic             modeActive
);
  ctlStrobe_t ctl;
  status_t    statRaw, statSync;
  logic       winExpired;
  logic [7:0] modeLatch;

  assign statRaw = '{ackN: statAckN, busy: statBusy, paperErr: statPaperErr,
                     select: statSel, faultN: statFaultN};

  xneg_datapath #(.DIV_W(DIV_W), .SETUP_T(SETUP_T), .RESP_T(RESP_T), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tickDiv(tickDiv), .modeCode(modeCode),
    .statRaw(statRaw), .statSync(statSync), .winExpired(winExpired), .modeLatch(modeLatch)
  );

  xneg_control u_ctl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .statSync(statSync), .winExpired(winExpired), .modeLatch(modeLatch), .ctl(ctl),
    .strobeN(outStrobeN), .autoFdN(outAutoFdN), .initN(outInitN), .selInN(outSelInN),
    .done(done), .result(result), .curMode(curMode), .modeActive(modeActive)
  );

  assign dataOut = modeLatch;
endmodule

// File: rtl/xneg_checker.sv
module xneg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       outStrobeN,
  input logic       outAutoFdN,
  input logic       outInitN,
  input logic       outSelInN,
  input logic [7:0] dataOut,
  input logic       done,
  input logic [2:0] result,
  input logic       modeActive
);
  p_init_high_r1: assert property (@(posedge clk) disable iff (!rst_n) outInitN);

  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 3'd4) |-> outSelInN);

  p_event1_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outSelInN) |-> (!outAutoFdN && outStrobeN && outInitN));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outSelInN && $past(outSelInN)) |-> $stable(dataOut));

  p_strobe_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outStrobeN) |-> (outSelInN && !outAutoFdN));

  p_strobe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outStrobeN) |-> outAutoFdN);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modeActive) |-> (done && result == 3'd0 && outSelInN));

  p_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modeActive) |-> !outSelInN);

  p_result_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= 3'd4));
endmodule

bind xmode_negotiator xneg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .outStrobeN(outStrobeN), .outAutoFdN(outAutoFdN),
  .outInitN(outInitN), .outSelInN(outSelInN), .dataOut(dataOut), .done(done),
  .result(result), .modeActive(modeActive)
);

// File: tb/sim_xmode_negotiator.sv
module sim_xmode_negotiator;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_T = 1;
  localparam int RESP_T  = 6;

  logic clk = 0, rst_n = 0;
  logic [7:0] tickDiv = 0;
  logic startReq = 0, stopReq = 0;
  logic [7:0] modeCode = 0;
  logic pAckN, pBusy, pErr, pSel, pFaultN;
  logic outStrobeN, outAutoFdN, outInitN, outSelInN, done, modeActive;
  logic [7:0] dataOut, curMode;
  logic [2:0] result;

  logic k1284 = 1, kAckOk = 1, kSel = 1, kTermBusy = 1, kTermAck = 1;
  int checks = 0, fails = 0, cycles = 0;
  logic expActive = 0;
  logic [7:0] expMode = 0, reqMode = 0;
  logic prevSel = 0, prevStb = 1;
  int stbLow = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmode_negotiator #(.DIV_W(8), .SETUP_T(SETUP_T), .RESP_T(RESP_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tickDiv(tickDiv), .startReq(startReq), .modeCode(modeCode),
    .stopReq(stopReq), .statAckN(pAckN), .statBusy(pBusy), .statPaperErr(pErr),
    .statSel(pSel), .statFaultN(pFaultN), .outStrobeN(outStrobeN), .outAutoFdN(outAutoFdN),
    .outInitN(outInitN), .outSelInN(outSelInN), .dataOut(dataOut), .done(done),
    .result(result), .curMode(curMode), .modeActive(modeActive)
  );

  // Peripheral model reacting to the host control lines
  always_comb begin
    pAckN = 1; pBusy = 0; pErr = 0; pSel = 1; pFaultN = 1;
    if (k1284) begin
      if (outSelInN && !outAutoFdN) begin pAckN = 0; pErr = 1; pSel = 1; end
      else if (outSelInN) begin pAckN = kAckOk; pErr = 1; pSel = kSel; end
      else if (!outAutoFdN) begin pAckN = kTermAck; end
      else begin pBusy = kTermBusy; pAckN = 0; end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expStartResult(logic [7:0] m);
    if (expActive) return 4;
    if (!k1284) return 1;
    if (!kAckOk) return 2;
    if (m != 8'h00 && !kSel) return 3;
    return 0;
  endfunction

  function automatic int expStopResult();
    if (!expActive) return 0;
    if (!kTermBusy || !kTermAck) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (outSelInN && !prevSel) begin
        chk(dataOut == reqMode, "R3 data on bus", dataOut, reqMode);
        chk(!outAutoFdN && outStrobeN && outInitN, "R3 event1 pins",
            {outStrobeN, outAutoFdN, outInitN}, 3'b101);
      end
      if (!outStrobeN) stbLow++;
      if (outStrobeN && !prevStb) begin
        chk(stbLow >= SETUP_T*(tickDiv+1) && stbLow <= SETUP_T*(tickDiv+1)+2,
            "R5 R11 strobe width", stbLow, SETUP_T*(tickDiv+1)+1);
        chk(outAutoFdN, "R5 autofd with strobe", outAutoFdN, 1);
        stbLow = 0;
      end
      prevSel = outSelInN;
      prevStb = outStrobeN;
    end
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  task automatic doStart(input logic [7:0] m);
    int cyc, er;
    logic selBefore;
    er = expStartResult(m);
    selBefore = outSelInN;
    reqMode = expActive ? reqMode : m;
    @(negedge clk); modeCode = m; startReq = 1;
    @(negedge clk); startReq = 0;
    waitDone(cyc);
    chk(done, "R2 R7 done seen", done, 1);
    chk(result == er, er == 4 ? "R2 refused" : er == 1 ? "R4 id timeout" :
        er == 2 ? "R6 protocol" : er == 3 ? "R7 not supported" : "R7 accepted", result, er);
    if (er == 0) begin expActive = 1; expMode = m; end
    if (er == 1)
      chk(cyc >= (2*SETUP_T+RESP_T)*(tickDiv+1) && cyc <= (2*SETUP_T+RESP_T)*(tickDiv+1)+5,
          "R11 timeout duration", cyc, (2*SETUP_T+RESP_T)*(tickDiv+1)+3);
    if (er == 4) chk(outSelInN == selBefore, "R2 pins unchanged", outSelInN, selBefore);
    @(negedge clk);
    chk(curMode == expMode && modeActive == expActive, "R7 mode state", curMode, expMode);
    chk(outSelInN == expActive && outAutoFdN && outStrobeN && outInitN, "R4 R6 R7 pins after",
        {outSelInN, outAutoFdN, outStrobeN}, {expActive, 2'b11});
  endtask

  task automatic doStop();
    int cyc, er;
    logic wasActive;
    er = expStopResult();
    wasActive = expActive;
    @(negedge clk); stopReq = 1;
    @(negedge clk); stopReq = 0;
    if (!wasActive)
      chk(!outSelInN && outAutoFdN, "R10 no pin change", outSelInN, 0);
    waitDone(cyc);
    chk(result == er, wasActive ? (er == 0 ? "R8 terminate" : "R9 term timeout") : "R10 idle stop",
        result, er);
    if (!wasActive) chk(cyc == 1, "R10 next cycle", cyc, 1);
    expActive = 0; expMode = 0;
    @(negedge clk);
    chk(curMode == 0 && !modeActive, "R8 R9 back to compat", curMode, 0);
    chk(!outSelInN && outAutoFdN && outStrobeN && outInitN, "R8 R9 idle pins",
        {outSelInN, outAutoFdN, outStrobeN}, 3'b011);
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(outStrobeN && outAutoFdN && outInitN && !outSelInN, "R1 reset pins",
        {outStrobeN, outAutoFdN, outInitN, outSelInN}, 4'b1110);
    chk(dataOut == 0 && curMode == 0 && !modeActive && !done, "R1 reset state", curMode, 0);

    // Directed corners
    kSel = 0; doStart(8'h00);           // R7 nibble accepted without select
    doStart(8'h30);                     // R2 refused while active
    kTermBusy = 1; kTermAck = 1; doStop(); // R8
    doStart(8'h30);                     // R7 not supported (select low)
    kSel = 1; doStart(8'h30);           // R7 accepted
    kTermBusy = 0; doStop();            // R9 first wait expires
    kTermBusy = 1; kTermAck = 0; doStart(8'h10); doStop(); // R9 second wait
    kTermAck = 1; doStop();             // R10
    tickDiv = 3; k1284 = 0; doStart(8'h30); // R4 R11
    k1284 = 1; kAckOk = 0; doStart(8'h30);  // R6

    // Constrained random
    for (int i = 0; i < 40; i++) begin
      tickDiv   = 8'($urandom_range(0, 3));
      k1284     = ($urandom_range(0, 5) != 0);
      kAckOk    = ($urandom_range(0, 5) != 0);
      kSel      = ($urandom_range(0, 2) != 0);
      kTermBusy = ($urandom_range(0, 4) != 0);
      kTermAck  = ($urandom_range(0, 4) != 0);
      if (expActive) k1284 = 1;
      if ($urandom_range(0, 2) == 0) doStop();
      else begin
        case ($urandom_range(0, 2))
          0: doStart(8'h00);
          1: doStart(8'h30);
          default: doStart(8'($urandom_range(0, 255)));
        endcase
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule